// File: doc/BRIEF.md
# Hashed Page Table Walker

The block services a translation miss by a single probe of a hashed page table held in memory. Every table slot carries the virtual page number, the address-space tag and the physical page number together with permission and status bits, so one read either finds the translation or proves that it is not in the first bucket. The slot index is an XOR fold of the page number and address-space tag. The slot address is formed by ORing the shifted index into a table base that is aligned to the size of the table, so no adder sits on the address path.

A matching slot with sufficient permission produces a TLB fill. The reference bit is set, and on a store the dirty bit is set too. The modified slot is written back only when one of those bits actually changes. A matching slot that forbids the access raises a protection fault. An invalid or non-matching slot raises a trap carrying the page number, the tag and the probed address, so that software can walk the overflow chain. One miss is handled at a time.

Top module: `hpt_walker`

## Requirements
- R1: `busy` is 1 from the cycle after a request is accepted until the cycle after its outcome pulse. A request presented while `busy` is 1 is ignored: it causes no read and no outcome.
- R2: The slot index bit i is the XOR of every page-number bit j and every tag bit j with j mod IDX_W equal to i.
- R3: The read address equals `tbl_base | (index << ENT_LOG2)`. The base must be aligned to 2^(IDX_W+ENT_LOG2).
- R4: Each walk issues exactly one read request, a pulse one cycle long.
- R5: Slot layout, MSB to LSB: valid, tag, page number, physical page, read-permit, write-permit, referenced, dirty (dirty at bit 0). A valid slot whose tag and page number match, and whose permit bit for the access is 1, gives a one-cycle `fill_valid` pulse with the physical page, both permit bits and the updated dirty bit.
- R6: A slot that is invalid, or whose tag or page number differs, gives a `trap_valid` pulse with the requested page number, tag and slot address, and no write.
- R7: A matching slot whose permit bit for the access is 0 gives a `fault_valid` pulse and no write.
- R8: On a fill the referenced bit is set, and for a store the dirty bit is set too. A write of the updated slot to the probed address comes in the fill cycle only if a bit changed.
- R9: The outcome pulse comes exactly one cycle after the cycle in which read data is returned.
- R10: After reset the walker is idle, with all request and outcome outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | ADDR_W | Table base address, size-aligned |
| req_valid | input | 1 | Translation miss request |
| req_vpn | input | VPN_W | Missing virtual page number |
| req_asid | input | ASID_W | Address-space tag of the miss |
| req_write | input | 1 | Access is a store |
| busy | output | 1 | Walk in progress; requests ignored |
| mem_rd_req | output | 1 | Slot read request |
| mem_addr | output | ADDR_W | Slot address for the read and the write |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | ENT_W | Slot contents |
| mem_wr_req | output | 1 | Write back the updated slot |
| mem_wr_data | output | ENT_W | Updated slot contents |
| fill_valid | output | 1 | Translation found |
| fill_ppn | output | PPN_W | Physical page number |
| fill_rd_ok | output | 1 | Read permitted |
| fill_wr_ok | output | 1 | Write permitted |
| fill_dirty | output | 1 | Updated dirty bit |
| fault_valid | output | 1 | Permission violation |
| trap_valid | output | 1 | First bucket missed |
| trap_vpn | output | VPN_W | Page number for the handler |
| trap_asid | output | ASID_W | Tag for the handler |
| trap_addr | output | ADDR_W | Probed slot address |

## Verification
The fill pulse and the status write-back share one cycle, and the write carries the slot as it is after the update. The bench provokes this with hits whose referenced or dirty bit starts clear, with loads and stores. In that same cycle it checks the fill fields, the write data and the write address. It then repeats the same access to the written slot and expects the fill without a write, which shows that an unchanged slot is left untouched.

// File: rtl/hptw_pkg.sv
package hptw_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} walk_st_e;
   typedef enum logic [1:0] {OC_FILL, OC_FAULT, OC_TRAP} outcome_e;
endpackage

// File: rtl/hptw_hash.sv
module hptw_hash #(
   parameter int VPN_W    = 20,
   parameter int ASID_W   = 8,
   parameter int IDX_W    = 6,
   parameter bit MIX_ASID = 1'b1
) (
   input  logic [VPN_W-1:0]  vpn,
   input  logic [ASID_W-1:0] asid,
   output logic [IDX_W-1:0]  idx
);
   logic [IDX_W-1:0] vpn_fold;
   logic [IDX_W-1:0] tag_fold;

   if (IDX_W < 1 || IDX_W > VPN_W) begin : g_bad_idx
      $error("hptw_hash: IDX_W must be in 1..VPN_W");
   end

   always_comb begin
      vpn_fold = '0;
      for (int j = 0; j < VPN_W; j++) vpn_fold[j % IDX_W] ^= vpn[j];
   end

   if (MIX_ASID) begin : g_mix
      always_comb begin
         tag_fold = '0;
         for (int j = 0; j < ASID_W; j++) tag_fold[j % IDX_W] ^= asid[j];
      end
   end else begin : g_nomix
      assign tag_fold = '0;
   end

   assign idx = vpn_fold ^ tag_fold;
endmodule

// File: rtl/hptw_addr.sv
module hptw_addr #(
   parameter int ADDR_W   = 32,
   parameter int IDX_W    = 6,
   parameter int ENT_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int SPAN = IDX_W + ENT_LOG2;
   localparam logic [ADDR_W-1:0] LOW_MASK = {{(ADDR_W-SPAN){1'b0}}, {SPAN{1'b1}}};

   if (SPAN >= ADDR_W) begin : g_bad_span
      $error("hptw_addr: table span exceeds address width");
   end

   logic [ADDR_W-1:0] off;
   assign off  = {{(ADDR_W-IDX_W){1'b0}}, idx} << ENT_LOG2;
   assign addr = base | off;

   // R3
   base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> ((base & LOW_MASK) == '0));
endmodule

// File: rtl/hptw_judge.sv
module hptw_judge
   import hptw_pkg::*;
#(
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8,
   parameter int PPN_W  = 16,
   localparam int ENT_W = 5 + PPN_W + VPN_W + ASID_W
) (
   input  logic [ENT_W-1:0]  ent,
   input  logic [VPN_W-1:0]  vpn,
   input  logic [ASID_W-1:0] asid,
   input  logic              is_wr,
   output outcome_e          kind,
   output logic [ENT_W-1:0]  upd,
   output logic              changed
);
   localparam int B_D    = 0;
   localparam int B_R    = 1;
   localparam int B_PW   = 2;
   localparam int B_PR   = 3;
   localparam int B_VPN  = 4 + PPN_W;
   localparam int B_ASID = B_VPN + VPN_W;
   localparam int B_V    = B_ASID + ASID_W;

   logic tag_ok, perm_ok;

   assign tag_ok  = ent[B_V] && (ent[B_VPN +: VPN_W] == vpn) &&
                    (ent[B_ASID +: ASID_W] == asid);
   assign perm_ok = is_wr ? ent[B_PW] : ent[B_PR];

   always_comb begin
      upd      = ent;
      upd[B_R] = 1'b1;
      if (is_wr) upd[B_D] = 1'b1;
   end

   assign changed = (upd != ent);
   assign kind    = !tag_ok ? OC_TRAP : (!perm_ok ? OC_FAULT : OC_FILL);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hptw_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int VPN_W    = 20,
   parameter int ASID_W   = 8,
   parameter int PPN_W    = 16,
   parameter int IDX_W    = 6,
   parameter int ENT_LOG2 = 4,
   parameter bit MIX_ASID = 1'b1,
   localparam int ENT_W   = 5 + PPN_W + VPN_W + ASID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic              req_valid,
   input  logic [VPN_W-1:0]  req_vpn,
   input  logic [ASID_W-1:0] req_asid,
   input  logic              req_write,
   output logic              busy,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rd_valid,
   input  logic [ENT_W-1:0]  mem_rd_data,
   output logic              mem_wr_req,
   output logic [ENT_W-1:0]  mem_wr_data,
   output logic              fill_valid,
   output logic [PPN_W-1:0]  fill_ppn,
   output logic              fill_rd_ok,
   output logic              fill_wr_ok,
   output logic              fill_dirty,
   output logic              fault_valid,
   output logic              trap_valid,
   output logic [VPN_W-1:0]  trap_vpn,
   output logic [ASID_W-1:0] trap_asid,
   output logic [ADDR_W-1:0] trap_addr
);
   localparam int B_PPN = 4;

   if (ENT_LOG2 < 0 || PPN_W < 1) begin : g_bad_cfg
      $error("hpt_walker: bad entry geometry");
   end

   walk_st_e          st;
   logic [VPN_W-1:0]  lat_vpn;
   logic [ASID_W-1:0] lat_asid;
   logic              lat_wr;
   logic [ADDR_W-1:0] lat_addr;
   logic [IDX_W-1:0]  slot_idx;
   logic [ADDR_W-1:0] slot_addr;
   logic              accept;
   outcome_e          kind;
   logic [ENT_W-1:0]  upd;
   logic              changed;

   assign accept = req_valid && (st == ST_IDLE);

   hptw_hash #(.VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W), .MIX_ASID(MIX_ASID)) u_hash (
      .vpn(req_vpn), .asid(req_asid), .idx(slot_idx));

   hptw_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)) u_addr (
      .clk(clk), .rst_n(rst_n), .chk_en(accept),
      .base(tbl_base), .idx(slot_idx), .addr(slot_addr));

   hptw_judge #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_judge (
      .ent(mem_rd_data), .vpn(lat_vpn), .asid(lat_asid), .is_wr(lat_wr),
      .kind(kind), .upd(upd), .changed(changed));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         lat_vpn     <= '0;
         lat_asid    <= '0;
         lat_wr      <= 1'b0;
         lat_addr    <= '0;
         fill_valid  <= 1'b0;
         fault_valid <= 1'b0;
         trap_valid  <= 1'b0;
         mem_wr_req  <= 1'b0;
         mem_wr_data <= '0;
         fill_ppn    <= '0;
         fill_rd_ok  <= 1'b0;
         fill_wr_ok  <= 1'b0;
         fill_dirty  <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (accept) begin
               lat_vpn  <= req_vpn;
               lat_asid <= req_asid;
               lat_wr   <= req_write;
               lat_addr <= slot_addr;
               st       <= ST_ISSUE;
            end
            ST_ISSUE: st <= ST_WAIT;
            ST_WAIT: if (mem_rd_valid) begin
               fill_valid  <= (kind == OC_FILL);
               fault_valid <= (kind == OC_FAULT);
               trap_valid  <= (kind == OC_TRAP);
               mem_wr_req  <= (kind == OC_FILL) && changed;
               mem_wr_data <= upd;
               fill_ppn    <= upd[B_PPN +: PPN_W];
               fill_rd_ok  <= upd[3];
               fill_wr_ok  <= upd[2];
               fill_dirty  <= upd[0];
               st          <= ST_DONE;
            end
            ST_DONE: begin
               fill_valid  <= 1'b0;
               fault_valid <= 1'b0;
               trap_valid  <= 1'b0;
               mem_wr_req  <= 1'b0;
               st          <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st != ST_IDLE);
   assign mem_rd_req = (st == ST_ISSUE);
   assign mem_addr   = lat_addr;
   assign trap_vpn   = lat_vpn;
   assign trap_asid  = lat_asid;
   assign trap_addr  = lat_addr;

   // R4
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);
   // R6
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fill_valid, fault_valid, trap_valid}));
   // R8
   wb_only_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> fill_valid);
   // R8
   wb_ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> mem_wr_data[1]);
   // R1
   outcome_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid || fault_valid || trap_valid) |=> !busy);
   // R9
   outcome_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && mem_rd_valid) |=> (fill_valid || fault_valid || trap_valid));
endmodule

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb_top;
   localparam int ADDR_W = 32, VPN_W = 20, ASID_W = 8, PPN_W = 16, IDX_W = 6, ENT_LOG2 = 4;
   localparam int ENT_W  = 5 + PPN_W + VPN_W + ASID_W;
   localparam logic [ADDR_W-1:0] BASE = 32'h0004_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [ADDR_W-1:0] tbl_base = BASE;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [VPN_W-1:0] req_vpn = '0;
   logic [ASID_W-1:0] req_asid = '0;
   logic busy, mem_rd_req, mem_wr_req, fill_valid, fill_rd_ok, fill_wr_ok, fill_dirty;
   logic fault_valid, trap_valid;
   logic [ADDR_W-1:0] mem_addr, trap_addr;
   logic mem_rd_valid;
   logic [ENT_W-1:0] mem_rd_data, mem_wr_data;
   logic [PPN_W-1:0] fill_ppn;
   logic [VPN_W-1:0] trap_vpn;
   logic [ASID_W-1:0] trap_asid;

   hpt_walker dut_i (.*);

   logic [ENT_W-1:0] mem [2**IDX_W];
   logic poke_en = 1'b0;
   logic [IDX_W-1:0] poke_idx = '0;
   logic [ENT_W-1:0] poke_data = '0;

   always @(posedge clk) begin
      mem_rd_valid <= mem_rd_req;
      mem_rd_data  <= mem[mem_addr[ENT_LOG2 +: IDX_W]];
      if (mem_wr_req) mem[mem_addr[ENT_LOG2 +: IDX_W]] <= mem_wr_data;
      if (poke_en) mem[poke_idx] <= poke_data;
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [IDX_W-1:0] hfold(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
      logic [IDX_W-1:0] h = '0;
      for (int i = 0; i < VPN_W; i++) h[i % IDX_W] = h[i % IDX_W] ^ v[i];
      for (int i = 0; i < ASID_W; i++) h[i % IDX_W] = h[i % IDX_W] ^ a[i];
      return h;
   endfunction

   function automatic logic [ENT_W-1:0] mk(input bit v, input logic [ASID_W-1:0] a,
         input logic [VPN_W-1:0] p, input logic [PPN_W-1:0] ppn,
         input bit pr, input bit pw, input bit rf, input bit d);
      return {v, a, p, ppn, pr, pw, rf, d};
   endfunction

   task automatic poke(input logic [IDX_W-1:0] i, input logic [ENT_W-1:0] e);
      @(negedge clk);
      poke_en = 1'b1; poke_idx = i; poke_data = e;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   // One walk with an optional intruding request while busy; expectations from entry e.
   task automatic walk(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input bit wr,
                       input logic [ENT_W-1:0] e, input bit intrude);
      logic [ADDR_W-1:0] exp_addr, raddr;
      bit tag_ok, perm_ok, exp_fill, exp_fault, exp_trap, exp_wb, got;
      logic [ENT_W-1:0] exp_upd;
      int reads, rv_cyc, oc;
      logic s_fill, s_fault, s_trap, s_wb, s_rd, s_wo, s_d;
      logic [ENT_W-1:0] s_wd;
      logic [PPN_W-1:0] s_ppn;
      logic [VPN_W-1:0] s_tv;
      logic [ASID_W-1:0] s_ta;
      logic [ADDR_W-1:0] s_taddr, s_maddr;
      exp_addr = BASE | ({26'd0, hfold(v, a)} << ENT_LOG2);
      tag_ok   = e[ENT_W-1] && e[ENT_W-2 -: ASID_W] == a && e[4+PPN_W +: VPN_W] == v;
      perm_ok  = wr ? e[2] : e[3];
      exp_trap = !tag_ok; exp_fault = tag_ok && !perm_ok; exp_fill = tag_ok && perm_ok;
      exp_upd  = e; exp_upd[1] = 1'b1; if (wr) exp_upd[0] = 1'b1;
      exp_wb   = exp_fill && (exp_upd != e);
      reads = 0; rv_cyc = -1; got = 0; oc = -1; raddr = '0;
      @(negedge clk);
      req_valid = 1'b1; req_vpn = v; req_asid = a; req_write = wr;
      @(negedge clk);
      req_valid = intrude; req_vpn = ~v; req_write = ~wr;
      chk(busy == 1'b1, "R1 busy after accept", busy, 1);
      for (int c = 0; c < 16 && !got; c++) begin
         if (c > 0) @(negedge clk);
         if (c == 1) req_valid = 1'b0;
         if (mem_rd_req) begin reads++; raddr = mem_addr; end
         if (mem_rd_valid && rv_cyc < 0) rv_cyc = c;
         if (fill_valid || fault_valid || trap_valid) begin
            got = 1; oc = c;
            s_fill = fill_valid; s_fault = fault_valid; s_trap = trap_valid;
            s_wb = mem_wr_req; s_wd = mem_wr_data; s_ppn = fill_ppn; s_rd = fill_rd_ok;
            s_wo = fill_wr_ok; s_d = fill_dirty; s_tv = trap_vpn; s_ta = trap_asid;
            s_taddr = trap_addr; s_maddr = mem_addr;
         end
      end
      chk(got, "R9 outcome seen", got, 1);
      chk(reads == 1, "R4 one read per walk", reads, 1);
      chk(raddr == exp_addr, "R2/R3 slot address", raddr, exp_addr);
      chk(oc == rv_cyc + 1, "R9 outcome one cycle after data", oc, rv_cyc + 1);
      chk({s_fill, s_fault, s_trap} == {exp_fill, exp_fault, exp_trap},
          "R5 R6 R7 outcome kind", {s_fill, s_fault, s_trap}, {exp_fill, exp_fault, exp_trap});
      chk(s_wb == exp_wb, "R8 write-back presence", s_wb, exp_wb);
      if (exp_fill) begin
         chk({s_ppn, s_rd, s_wo, s_d} == {exp_upd[4 +: PPN_W], exp_upd[3], exp_upd[2], exp_upd[0]},
             "R5 fill fields", {s_ppn, s_rd, s_wo, s_d},
             {exp_upd[4 +: PPN_W], exp_upd[3], exp_upd[2], exp_upd[0]});
         if (exp_wb) begin
            chk(s_wd == exp_upd, "R8 write-back data", s_wd, exp_upd);
            chk(s_maddr == exp_addr, "R8 write-back address", s_maddr, exp_addr);
         end
      end
      if (exp_trap)
         chk({s_tv, s_ta, s_taddr} == {v, a, exp_addr}, "R6 trap report",
             {s_tv, s_ta, s_taddr}, {v, a, exp_addr});
      @(negedge clk);
      chk(!busy && !mem_rd_req, "R1 released, intruder ignored", {busy, mem_rd_req}, 0);
      @(negedge clk);
      chk(!mem_rd_req && !busy, "R1 no late walk", {busy, mem_rd_req}, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [VPN_W-1:0] v;
      logic [ASID_W-1:0] a;
      logic [ENT_W-1:0] e;
      bit wr;
      void'($urandom(32'd4242));
      for (int i = 0; i < 2**IDX_W; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk({busy, mem_rd_req, mem_wr_req, fill_valid, fault_valid, trap_valid} == 0,
          "R10 reset outputs", {busy, mem_rd_req, mem_wr_req, fill_valid, fault_valid, trap_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy, "R10 idle after reset", busy, 0);

      // Directed: hit load with clear status -> fill and write-back in same cycle (R8)
      v = 20'hFFFFF; a = 8'h00;
      e = mk(1, a, v, 16'hBEEF, 1, 1, 0, 0);
      poke(hfold(v, a), e); walk(v, a, 0, e, 1);
      // repeat: referenced already set -> no write (R8)
      e = mk(1, a, v, 16'hBEEF, 1, 1, 1, 0);
      walk(v, a, 0, e, 0);
      // store -> dirty set, write-back (R8)
      walk(v, a, 1, e, 0);
      e = mk(1, a, v, 16'hBEEF, 1, 1, 1, 1);
      walk(v, a, 1, e, 0);
      // R7 store to read-only slot
      v = 20'h00000; a = 8'hFF;
      e = mk(1, a, v, 16'h1234, 1, 0, 0, 0);
      poke(hfold(v, a), e); walk(v, a, 1, e, 0);
      // R7 load with read not permitted
      e = mk(1, a, v, 16'h1234, 0, 1, 0, 0);
      poke(hfold(v, a), e); walk(v, a, 0, e, 1);
      // R6 invalid slot with matching tags
      e = mk(0, a, v, 16'h1234, 1, 1, 0, 0);
      poke(hfold(v, a), e); walk(v, a, 0, e, 0);
      // R6 tag mismatch only
      e = mk(1, a ^ 8'h01, v, 16'h1234, 1, 1, 0, 0);
      poke(hfold(v, a), e); walk(v, a, 0, e, 0);

      // Random walks
      for (int n = 0; n < 150; n++) begin
         int sc;
         v = 20'($urandom); a = 8'($urandom); wr = 1'($urandom);
         sc = int'($urandom % 5);
         case (sc)
            0, 1, 2: e = mk(1, a, v, 16'($urandom), 1'($urandom % 4 != 0), 1'($urandom % 4 != 0),
                            1'($urandom), 1'($urandom));
            3:       e = mk(1, a, v ^ 20'(1 << ($urandom % 20)), 16'($urandom), 1, 1, 0, 0);
            default: e = mk(0, a, v, 16'($urandom), 1, 1, 0, 0);
         endcase
         poke(hfold(v, a), e);
         walk(v, a, wr, e, 1'($urandom));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule